// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of level-sensitive device request lines and a processor core. Each source carries a configurable urgency level. The controller holds a current-priority register, and that register acts as a mask: a source can reach the core only when its level is strictly above the current priority and the global enable is set. When the core takes a request, the controller does four things in one step:

- raises the current priority to the level of the request it took, so the same source, and any source at or below that level, cannot re-enter;
- moves the privilege bit to supervisor;
- clears the global enable;
- reports the table slot the core should jump through.

A synchronous trap or exception strobe from the core is always taken. It also pushes state, enters supervisor mode and clears the enable, but it leaves the priority as it is. Each entry pushes the prior priority and mode onto a four-deep stack, and a return strobe pops them back. Handlers can therefore nest: a more urgent source may interrupt the handler of a less urgent one, and the return path unwinds level by level.

The core-side request is a valid/ready pair. `irq_valid` is combinational from the current request lines and state. While it is held and `irq_ready` is low, the offered index and level may change, because the device lines are level-sensitive. Nothing is taken until both are high in the same cycle. Handler software clears the device line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the current priority is 0, the mode bit is 0 (user), the global enable is 0, and `irq_valid`, `entry_stb` and `stk_ovf` are all 0.
- R2: `irq_valid` is 1 only in these conditions, all at once:
  - the global enable is 1;
  - some requesting source has a level strictly above the current priority;
  - neither `trap_stb` nor `ret_stb` is high in that cycle.
  A source with level 0 is never offered.
- R3: Among eligible sources the highest level wins, and the lowest index breaks ties. `irq_vec` is the winner's index and `irq_lvl` is its level. The level of source i is `src_lvl[i*LVL_W +: LVL_W]`.
- R4: An interrupt is taken when `irq_valid` and `irq_ready` are both high. On the next cycle the current priority equals the taken level, `sup_mode` is 1 and `gie` is 0. A request at that same level is then no longer offered.
- R5: Once `gie` is set again inside a handler, a source whose level is above the current priority is offered and may be taken. A source at or below that level is not offered.
- R6: On the cycle after any entry, `entry_stb` is high for one cycle and `entry_slot` gives the slot:
  - for an interrupt, the source index;
  - for a trap, NUM_SRC plus `trap_code`.
- R7: `trap_stb` is taken whatever the enable and priority are. On the next cycle `sup_mode` is 1, `gie` is 0 and the priority is unchanged.
- R8: `ret_stb` with a non-empty stack restores the priority and mode saved by the most recent entry, in last-in first-out order.
- R9: `ret_stb` with an empty stack leaves the priority and mode unchanged.
- R10: The stack holds four entries. An entry made while it is full still takes effect, but its saved state is dropped and `stk_ovf` goes to 1. `stk_ovf` stays at 1 until reset.
- R11: `gie_set` sets `gie` on the next cycle. If an entry is taken in the same cycle, the entry's clear wins.
- R12: When `trap_stb` and `ret_stb` are high in the same cycle, the trap is taken and the return is ignored.
- R13: `irq_ready` without `irq_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Level-sensitive device requests |
| src_lvl | input | NUM_SRC*LVL_W | Packed per-source urgency levels |
| gie_set | input | 1 | Write strobe that sets the global enable |
| irq_valid | output | 1 | Interrupt offered to the core |
| irq_ready | input | 1 | Core acknowledge |
| irq_vec | output | IDX_W | Index of the offered source |
| irq_lvl | output | LVL_W | Level of the offered source |
| trap_stb | input | 1 | Synchronous trap or exception entry |
| trap_code | input | CODE_W | Trap number |
| ret_stb | input | 1 | Return-from-exception strobe |
| entry_stb | output | 1 | One-cycle pulse after any entry |
| entry_slot | output | SLOT_W | Vector-table slot of that entry |
| cur_prio | output | LVL_W | Current priority mask |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| gie | output | 1 | Global interrupt enable |
| stk_ovf | output | 1 | Sticky stack overflow flag |

## Verification
The directed run covers four patterns:
- two sources at equal level, which separates tie-breaking by index from tie-breaking by level;
- a same-level re-request after acceptance, which separates masking from plain forwarding;
- a higher-level request inside a handler, which shows nesting;
- three returns in a row, the last on an empty stack, which checks LIFO restore and the empty case.

Trap-only bursts past four entries show the overflow flag, and a trap together with a return shows the priority between them. Random request masks, levels, acknowledges and strobes, all from a fixed seed, are checked every cycle against a reference model. That model holds its own priority, mode, enable and stack.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } priv_mode_e;

endpackage

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       req,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);

  logic [LVL_W-1:0] lvl_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl_arr[g] = lvl_flat[g*LVL_W +: LVL_W];
  end

  // strict compare keeps the lowest index among equal levels
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (lvl_arr[i] > win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl_arr[i];
      end
    end
  end

endmodule

// File: rtl/irqc_stack.sv
module irqc_stack #(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] top_ptr;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign top_ptr = PTR_W'(cnt - 1'b1);
  assign top     = empty ? '0 : mem[top_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      mem[PTR_W'(cnt)] <= din;
      cnt              <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> full);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int CODE_W  = 2,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int SLOT_W = $clog2(NUM_SRC + (1 << CODE_W))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       src_req,
  input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
  input  logic                     gie_set,
  output logic                     irq_valid,
  input  logic                     irq_ready,
  output logic [IDX_W-1:0]         irq_vec,
  output logic [LVL_W-1:0]         irq_lvl,
  input  logic                     trap_stb,
  input  logic [CODE_W-1:0]        trap_code,
  input  logic                     ret_stb,
  output logic                     entry_stb,
  output logic [SLOT_W-1:0]        entry_slot,
  output logic [LVL_W-1:0]         cur_prio,
  output logic                     sup_mode,
  output logic                     gie,
  output logic                     stk_ovf
);

  localparam int SW = LVL_W + 1;

  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [LVL_W-1:0] pick_lvl;
  logic [LVL_W-1:0] prio_q;
  priv_mode_e       mode_q;
  logic             gie_q;
  logic             accept_irq, do_push, do_ret;
  logic             stk_empty, stk_full;
  logic [SW-1:0]    stk_top;

  irqc_pick #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) pick_i (
    .req      (src_req),
    .lvl_flat (src_lvl),
    .found    (pick_found),
    .win_idx  (pick_idx),
    .win_lvl  (pick_lvl)
  );

  assign irq_valid  = gie_q && pick_found && (pick_lvl > prio_q) && !trap_stb && !ret_stb;
  assign irq_vec    = pick_idx;
  assign irq_lvl    = pick_lvl;
  assign accept_irq = irq_valid && irq_ready;
  assign do_push    = trap_stb || accept_irq;
  assign do_ret     = ret_stb && !trap_stb && !stk_empty;

  irqc_stack #(.W(SW), .DEPTH(DEPTH)) stack_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_push),
    .pop   (do_ret),
    .din   ({prio_q, mode_q}),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q     <= '0;
      mode_q     <= MODE_USER;
      gie_q      <= 1'b0;
      entry_stb  <= 1'b0;
      entry_slot <= '0;
      stk_ovf    <= 1'b0;
    end else begin
      entry_stb <= do_push;
      if (do_push && stk_full) stk_ovf <= 1'b1;
      if (trap_stb) begin
        mode_q     <= MODE_SUP;
        gie_q      <= 1'b0;
        entry_slot <= SLOT_W'(NUM_SRC) + SLOT_W'(trap_code);
      end else if (accept_irq) begin
        prio_q     <= pick_lvl;
        mode_q     <= MODE_SUP;
        gie_q      <= 1'b0;
        entry_slot <= SLOT_W'(pick_idx);
      end else begin
        if (do_ret) begin
          prio_q <= stk_top[SW-1:1];
          mode_q <= priv_mode_e'(stk_top[0]);
        end
        if (gie_set) gie_q <= 1'b1;
      end
    end
  end

  assign cur_prio = prio_q;
  assign sup_mode = (mode_q == MODE_SUP);
  assign gie      = gie_q;

  p_pick_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> (src_req[pick_idx] && (src_lvl[pick_idx*LVL_W +: LVL_W] == pick_lvl)));

  p_accept_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_irq |=> ((cur_prio == $past(pick_lvl)) && sup_mode && !gie));

  p_entry_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> entry_stb);

  p_trap_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_stb |=> ((cur_prio == $past(cur_prio)) && sup_mode && !gie));

  p_ret_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && !trap_stb && stk_empty) |=> ($stable(cur_prio) && $stable(sup_mode)));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf);

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

  localparam int NS = 8;
  localparam int LW = 3;
  localparam int CW = 2;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic [NS*LW-1:0] src_lvl = '0;
  logic          gie_set = 1'b0, irq_ready = 1'b0, trap_stb = 1'b0, ret_stb = 1'b0;
  logic [CW-1:0] trap_code = '0;
  logic          irq_valid, entry_stb, sup_mode, gie, stk_ovf;
  logic [2:0]    irq_vec;
  logic [LW-1:0] irq_lvl, cur_prio;
  logic [3:0]    entry_slot;

  prio_irq_ctrl #(.NUM_SRC(NS), .LVL_W(LW), .CODE_W(CW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_lvl(src_lvl),
    .gie_set(gie_set), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .trap_stb(trap_stb),
    .trap_code(trap_code), .ret_stb(ret_stb), .entry_stb(entry_stb),
    .entry_slot(entry_slot), .cur_prio(cur_prio), .sup_mode(sup_mode),
    .gie(gie), .stk_ovf(stk_ovf)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int m_prio, m_mode, m_gie, m_ovf, sp;
  int stk_p [DP];
  int stk_m [DP];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_pick(input logic [NS-1:0] rq, input logic [NS*LW-1:0] lv,
                                   output int f, output int idx, output int l);
    f = 0; idx = 0; l = 0;
    for (int i = 0; i < NS; i++) begin
      int li;
      li = int'(lv[i*LW +: LW]);
      if (rq[i] && li > l) begin f = 1; idx = i; l = li; end
    end
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_req = '0; gie_set = 0; irq_ready = 0; trap_stb = 0; ret_stb = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    m_prio = 0; m_mode = 0; m_gie = 0; m_ovf = 0; sp = 0;
    chk("R1 prio", int'(cur_prio), 0);
    chk("R1 mode", int'(sup_mode), 0);
    chk("R1 gie", int'(gie), 0);
    chk("R1 valid", int'(irq_valid), 0);
    chk("R1 entry", int'(entry_stb), 0);
    chk("R1 ovf", int'(stk_ovf), 0);
  endtask

  task automatic step(input logic [NS-1:0] rq, input bit rdy, input bit trp,
                      input logic [CW-1:0] code, input bit rt, input bit gs);
    int f, idx, l, ev, acc, push, slot;
    @(negedge clk);
    src_req = rq; irq_ready = rdy; trap_stb = trp; trap_code = code;
    ret_stb = rt; gie_set = gs;
    #1;
    ref_pick(rq, src_lvl, f, idx, l);
    ev = (m_gie != 0 && f != 0 && l > m_prio && !trp && !rt) ? 1 : 0;
    chk("R2/R5/R12 valid", int'(irq_valid), ev);
    if (ev != 0) begin
      chk("R3 vec", int'(irq_vec), idx);
      chk("R3 lvl", int'(irq_lvl), l);
    end
    acc  = (ev != 0 && rdy) ? 1 : 0;
    push = (trp || acc != 0) ? 1 : 0;
    slot = trp ? NS + int'(code) : idx;
    if (push != 0) begin
      if (sp == DP) m_ovf = 1;
      else begin stk_p[sp] = m_prio; stk_m[sp] = m_mode; sp++; end
    end
    if (trp) begin
      m_mode = 1; m_gie = 0;
    end else if (acc != 0) begin
      m_prio = l; m_mode = 1; m_gie = 0;
    end else begin
      if (rt && sp > 0) begin sp--; m_prio = stk_p[sp]; m_mode = stk_m[sp]; end
      if (gs) m_gie = 1;
    end
    @(posedge clk);
    #1;
    chk("R6/R13 entry_stb", int'(entry_stb), push);
    if (push != 0) chk("R6 slot", int'(entry_slot), slot);
    chk("R4/R7/R8/R9 prio", int'(cur_prio), m_prio);
    chk("R4/R7/R8/R9 mode", int'(sup_mode), m_mode);
    chk("R4/R11 gie", int'(gie), m_gie);
    chk("R10 ovf", int'(stk_ovf), m_ovf);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // levels: src0=2 src1=5 src2=2 src3=0 src4=7 others 1
    src_lvl = {3'd1, 3'd1, 3'd1, 3'd7, 3'd0, 3'd2, 3'd5, 3'd2};
    do_reset();
    step(8'h01, 1, 0, 0, 0, 0);          // R2: enable off, not offered
    step(8'h00, 0, 0, 0, 0, 1);          // R11
    step(8'h05, 1, 0, 0, 0, 0);          // R3 tie -> src0, R4
    step(8'h00, 0, 0, 0, 0, 1);
    step(8'h01, 1, 0, 0, 0, 0);          // R4 same level masked
    step(8'h08, 1, 0, 0, 0, 0);          // level 0 source
    step(8'h03, 0, 0, 0, 0, 0);          // R13 held valid, no ready
    step(8'h03, 1, 0, 0, 0, 0);          // R5 nest src1
    step(8'h00, 1, 0, 0, 0, 0);          // R13 ready without valid
    step(8'h00, 0, 0, 0, 1, 0);          // R8 back to 2
    step(8'h00, 0, 0, 0, 1, 0);          // R8 back to 0 user
    step(8'h00, 0, 0, 0, 1, 0);          // R9 empty
    step(8'h10, 1, 1, 2'd3, 1, 1);       // R12 trap beats ret, R6 slot 11, R7
    step(8'h00, 0, 0, 0, 1, 0);
    do_reset();
    for (int k = 0; k < 5; k++) step(8'h00, 0, 1, CW'(k), 0, 0);  // R10
    for (int k = 0; k < 5; k++) step(8'h00, 0, 0, 0, 1, 0);
    for (int r = 0; r < 4; r++) begin
      for (int s = 0; s < NS; s++) src_lvl[s*LW +: LW] = LW'($urandom);
      do_reset();
      for (int n = 0; n < 800; n++) begin
        step(NS'($urandom), 1'($urandom), ($urandom % 16) == 0, CW'($urandom),
             ($urandom % 6) == 0, ($urandom % 3) == 0);
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule